// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block is the slave side of a three-wire stereo serial audio link plus a return data line. An external master supplies a bit clock and a word clock; the block oversamples both, together with the serial data input, on its own system clock. It collects one 16-bit receive sample per word-clock half and hands it to the core as a parallel word with a one-cycle strobe for the left or the right channel. In the other direction it takes a left and a right parallel word from the core and shifts them out on the serial data output.

The two directions use different alignments within a half-frame. Receive data is right-justified: the sample occupies the last 16 bit clocks before the word-clock edge, whatever the frame length. Transmit data is left-justified: the most significant bit appears with the word-clock edge and the remaining bits follow on each bit-clock fall. A word-clock period may hold 32, 48 or 64 bit clocks, and the block needs no setting to know which.

Top module: `stereo_audio_port`

## Requirements
- R1: While reset is high and in the cycle after it is released, `sdo` is 0, both receive words are 0 and both receive strobes are 0.
- R2: Receive words are 16-bit two's complement, first bit received is the MSB, and the word is formed by the last 16 bits sampled before the word-clock edge; earlier bits of a longer half-frame are ignored.
- R3: Word clock high marks the left channel and low the right channel; the word of a half-frame is presented on `rx_left`/`rx_right` with its strobe at the first bit-clock rise of the following half-frame.
- R4: Each strobe lasts exactly one cycle, the two strobes never assert together, and each half-frame yields exactly one strobe.
- R5: Transmit data is left-justified: bit 15 of the word is on `sdo` from the word-clock edge, and bit 15-k is on `sdo` after the k-th following bit-clock fall (k = 1..15).
- R6: After the 16 data bits of a half-frame, `sdo` stays 0 until the next word-clock edge.
- R7: Frames of 32, 48 and 64 bit clocks per word-clock period are all received and transmitted correctly without configuration.
- R8: `sdi` is sampled on bit-clock rises; `sdo` changes only after a bit-clock fall or a word-clock edge.
- R9: `tx_left` is captured at the rising word-clock edge and `tx_right` at the falling one; changing either input during its half-frame has no effect on `sdo`.
- R10: All-zero transmit words produce an all-zero `sdo` stream.
- R11: When a word-clock edge and a bit-clock fall are seen in the same cycle, the new word is loaded and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bck | input | 1 | External bit clock |
| wck | input | 1 | External word clock, high = left |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| rx_left | output | 16 | Last received left word |
| rx_right | output | 16 | Last received right word |
| rx_left_vld | output | 1 | One-cycle strobe: new left word |
| rx_right_vld | output | 1 | One-cycle strobe: new right word |
| tx_left | input | 16 | Left word to transmit |
| tx_right | input | 16 | Right word to transmit |

## Verification
The word-clock edge and the bit-clock fall that follows every bit-clock period arrive together, because the master moves both lines at the same instant; the transmitter must then load the fresh word and skip the shift. The bench drives the two lines in the same step at every half-frame start, so both are seen in one system cycle, and judges the outcome by the bit on `sdo` just before the next rise: it must be bit 15 of the new word, not bit 14. The receiver meets a similar collision, latching the finished word and shifting the first new bit on the same rise, judged by the presented word matching the previous half exactly.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int unsigned WORD_W      = 16;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;

    // events derived from the oversampled serial lines, all for one cycle
    typedef struct packed {
        logic rise;    // bit clock went high
        logic fall;    // bit clock went low
        logic wedge;   // word clock changed level
        logic wlevel;  // current word clock level
        logic sdata;   // current serial input level
    } line_ev_t;
endpackage

// File: rtl/sap_line_sync.sv
module sap_line_sync
    import sap_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bck_in,
    input  logic     wck_in,
    input  logic     sd_in,
    output line_ev_t ev
);
    localparam int unsigned LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             bck_d;
    logic             wck_d;

    assign raw = {bck_in, wck_in, sd_in};

    generate
        if (STAGES <= 1) begin : g_single
            logic [LINES-1:0] st;
            always_ff @(posedge clk) begin
                if (rst) st <= '0;
                else     st <= raw;
            end
            assign synced = st;
        end else begin : g_chain
            logic [LINES-1:0] st [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(STAGES); i++) st[i] <= '0;
                end else begin
                    st[0] <= raw;
                    for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
                end
            end
            assign synced = st[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_d <= 1'b0;
            wck_d <= 1'b0;
        end else begin
            bck_d <= synced[2];
            wck_d <= synced[1];
        end
    end

    always_comb begin
        ev.rise   =  synced[2] & ~bck_d;
        ev.fall   = ~synced[2] &  bck_d;
        ev.wedge  =  synced[1] ^  wck_d;
        ev.wlevel =  synced[1];
        ev.sdata  =  synced[0];
    end
endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise,
    input  logic         wlevel,
    input  logic         sdata,
    output logic [W-1:0] left_word,
    output logic [W-1:0] right_word,
    output logic         left_vld,
    output logic         right_vld
);
    logic [W-1:0] shreg;
    chan_e        chan_last;

    // the shift register runs on every rise, so the last W bits of any
    // half-frame length are present when the word clock turns
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            chan_last  <= CH_RIGHT;
            left_word  <= '0;
            right_word <= '0;
            left_vld   <= 1'b0;
            right_vld  <= 1'b0;
        end else begin
            left_vld  <= 1'b0;
            right_vld <= 1'b0;
            if (rise) begin
                shreg     <= {shreg[W-2:0], sdata};
                chan_last <= chan_e'(wlevel);
                if (chan_e'(wlevel) != chan_last) begin
                    if (chan_last == CH_LEFT) begin
                        left_word <= shreg;
                        left_vld  <= 1'b1;
                    end else begin
                        right_word <= shreg;
                        right_vld  <= 1'b1;
                    end
                end
            end
        end
    end

    // R4
    left_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        left_vld |=> !left_vld);
    // R4
    right_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        right_vld |=> !right_vld);
    // R4
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(left_vld && right_vld));
    // R8
    strobe_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (left_vld || right_vld) |-> $past(rise));
endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fall,
    input  logic         wedge,
    input  logic         wlevel,
    input  logic [W-1:0] tx_left,
    input  logic [W-1:0] tx_right,
    output logic         sdo
);
    logic [W-1:0] shreg;

    // load has priority over shift when both events share a cycle;
    // zeros fill from the bottom so bits past the W-th are 0
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (wedge) begin
            shreg <= (chan_e'(wlevel) == CH_LEFT) ? tx_left : tx_right;
        end else if (fall) begin
            shreg <= {shreg[W-2:0], 1'b0};
        end
    end

    assign sdo = shreg[W-1];

    // R11
    load_msb_chk: assert property (@(posedge clk) disable iff (rst)
        wedge |=> (sdo == $past(wlevel ? tx_left[W-1] : tx_right[W-1])));
    // R8
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wedge && !fall) |=> $stable(sdo));
endmodule

// File: rtl/stereo_audio_port.sv
module stereo_audio_port
    import sap_pkg::*;
#(
    parameter int unsigned W      = WORD_W,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bck,
    input  logic         wck,
    input  logic         sdi,
    output logic         sdo,
    output logic [W-1:0] rx_left,
    output logic [W-1:0] rx_right,
    output logic         rx_left_vld,
    output logic         rx_right_vld,
    input  logic [W-1:0] tx_left,
    input  logic [W-1:0] tx_right
);
    line_ev_t ev;

    sap_line_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .bck_in (bck),
        .wck_in (wck),
        .sd_in  (sdi),
        .ev     (ev)
    );

    sap_rx #(.W(W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rise       (ev.rise),
        .wlevel     (ev.wlevel),
        .sdata      (ev.sdata),
        .left_word  (rx_left),
        .right_word (rx_right),
        .left_vld   (rx_left_vld),
        .right_vld  (rx_right_vld)
    );

    sap_tx #(.W(W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .fall     (ev.fall),
        .wedge    (ev.wedge),
        .wlevel   (ev.wlevel),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .sdo      (sdo)
    );
endmodule

// File: tb/tb_stereo_audio_port.sv
`timescale 1ns/1ps
module tb_stereo_audio_port;
    localparam int HALF = 8;   // system clocks per bit-clock phase
    localparam int NV   = 6;

    localparam int          V_LEN [NV] = '{32, 48, 64, 64, 32, 48};
    localparam logic [15:0] V_RXL [NV] = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'hFFFF, 16'h0000, 16'h1234};
    localparam logic [15:0] V_RXR [NV] = '{16'h3C5A, 16'h0001, 16'h8000, 16'h0F0F, 16'hFFFF, 16'hFEDC};
    localparam logic [15:0] V_TXL [NV] = '{16'hC001, 16'h5A5A, 16'hFFFF, 16'h8421, 16'h0000, 16'h7FFF};
    localparam logic [15:0] V_TXR [NV] = '{16'h1357, 16'hA5A5, 16'hFFFF, 16'h0001, 16'h0000, 16'h8000};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bck = 1'b1;
    logic        wck = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [15:0] rx_left, rx_right, tx_left, tx_right;
    logic        rx_left_vld, rx_right_vld;

    int n_chk = 0;
    int n_bad = 0;
    int n_lv  = 0;
    logic [15:0] got_l = '0;
    logic [15:0] got_r = '0;

    always #2.5 clk = ~clk;

    stereo_audio_port dut (
        .clk(clk), .rst(rst), .bck(bck), .wck(wck), .sdi(sdi), .sdo(sdo),
        .rx_left(rx_left), .rx_right(rx_right),
        .rx_left_vld(rx_left_vld), .rx_right_vld(rx_right_vld),
        .tx_left(tx_left), .tx_right(tx_right)
    );

    always @(posedge clk) begin
        if (rx_left_vld)  begin got_l <= rx_left;  n_lv <= n_lv + 1; end
        if (rx_right_vld) got_r <= rx_right;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one half-frame: drive receive bits right-justified, check transmit bits
    task automatic send_half(int nh, logic lvl, logic [15:0] rxw, logic [15:0] txw);
        for (int i = 0; i < nh; i++) begin
            @(negedge clk);
            bck = 1'b0;
            wck = lvl;
            if (i >= nh - 16) sdi = rxw[nh - 1 - i];
            else              sdi = 1'b1;          // ignored padding (R2)
            if (i == 3) begin                       // R9: late change ignored
                if (lvl) tx_left  = ~tx_left;
                else     tx_right = ~tx_right;
            end
            repeat (HALF) @(negedge clk);
            if (i == 0)       check("R11 R5 msb at word edge", {31'd0, sdo}, {31'd0, txw[15]});
            else if (i < 16)  check("R5 R9 R10 tx bit", {31'd0, sdo}, {31'd0, txw[15 - i]});
            else              check("R6 R7 tx pad bit", {31'd0, sdo}, 32'd0);
            bck = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    initial begin
        tx_left  = '0;
        tx_right = '0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 sdo", {31'd0, sdo}, 32'd0);
        check("R1 rx_left", {16'd0, rx_left}, 32'd0);
        check("R1 strobes", {30'd0, rx_left_vld, rx_right_vld}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {15'd0, sdo, rx_right}, 32'd0);
        repeat (6) @(negedge clk);

        for (int j = 0; j < NV; j++) begin
            tx_left  = V_TXL[j];
            tx_right = V_TXR[j];
            send_half(V_LEN[j] / 2, 1'b1, V_RXL[j], V_TXL[j]);
            send_half(V_LEN[j] / 2, 1'b0, V_RXR[j], V_TXR[j]);
            check("R2 R3 R7 left word", {16'd0, got_l}, {16'd0, V_RXL[j]});
            check("R4 one left strobe per frame", n_lv, j + 1);
            if (j > 0)
                check("R2 R3 R7 right word", {16'd0, got_r}, {16'd0, V_RXR[j-1]});
        end
        tx_left  = '0;
        tx_right = '0;
        send_half(16, 1'b1, 16'h0000, 16'h0000);
        check("R3 last right word", {16'd0, got_r}, {16'd0, V_RXR[NV-1]});
        send_half(16, 1'b0, 16'h0000, 16'h0000);
        check("R10 mute left word in", {16'd0, got_l}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule